// File: doc/BRIEF.md
# Dual-Clock FIFO with Threshold Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on the write clock and a consumer pulls them on the read clock. The storage is an inferred two-port memory with one write port and one registered read port. Binary pointers, Gray-coded copies of those pointers and the flag logic surround the memory. Each pointer is one bit wider than the address. Its Gray copy reaches the other domain through two flip-flop stages.

Every flag is computed in the domain that uses it. A flag goes true on the edge at which that domain's own pointer creates the condition. A flag goes false only after the other pointer has crossed over. Full and empty are therefore pessimistic: they never report room or data that might not exist. Two parameters set the thresholds for almost-full and almost-empty.

A separate read-clock input returns only the read pointer to address zero. Stored words and the write pointer keep their values, so the consumer can replay the buffer from its start.

Top module: `xclk_fifo`

## Requirements
- R1: While `rst` is high and on the cycles that follow it, both pointers are zero, `rd_empty` and `rd_almost_empty` are 1, and `wr_full` and `wr_almost_full` are 0.
- R2: `wr_full` is 1 right after the write-clock edge that stores the DEPTH-th unread word. `rd_empty` is 1 right after the read-clock edge that removes the last word. Neither flag waits for a synchronizer.
- R3: After a write into an empty FIFO, `rd_empty` stays 1 for at least the first read-clock edge after the write edge. It goes to 0 within three read-clock cycles.
- R4: After a read from a full FIFO, `wr_full` stays 1 for at least the first write-clock edge after the read edge. It goes to 0 within four write-clock cycles.
- R5: A word is stored only on a write-clock edge where `wr_en` is 1 and `wr_full` is 0. A write while full is dropped, and the write pointer does not move.
- R6: A word is removed only on a read-clock edge where `rd_en` is 1 and `rd_empty` is 0. A read while empty is ignored, and the read pointer does not move.
- R7: `rd_data` shows the oldest unread word one read-clock cycle after an accepted read. Words leave in the order they were accepted.
- R8: `wr_almost_full` is 1 exactly when the write-side fill count is at least AFULL_LVL (default 12). The count is the write pointer minus the synchronized read pointer.
- R9: `rd_almost_empty` is 1 exactly when the read-side fill count is at most AEMPTY_LVL (default 2). The count is the synchronized write pointer minus the read pointer.
- R10: A read-clock cycle with `rd_ptr_clr` high sets the read pointer to zero and leaves the write pointer and the stored words unchanged. Reads then restart at address 0.
- R11: Capacity is DEPTH = 2^ADDR_W words (default 16). Exactly DEPTH writes into an empty FIFO are accepted before `wr_full` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Global synchronous reset, active high, seen by both clocks |
| rd_ptr_clr | input | 1 | Read-clock pulse that sets only the read pointer to zero |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room for another word |
| wr_almost_full | output | 1 | Fill count at or above AFULL_LVL |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Registered output word |
| rd_empty | output | 1 | No unread word |
| rd_almost_empty | output | 1 | Fill count at or below AEMPTY_LVL |

## Verification
Single words spaced apart expose the delay before empty clears. This separates the immediate rise of a flag from its synchronized fall. A fill past capacity, followed by a drain, walks both threshold flags through every fill level. It also shows that the extra write is dropped and leaves no gap in the output order. A partial drain followed by a read-pointer clear tells a replay from address 0 apart from a full reset. A later write to address 5 proves the write pointer kept its value. A long run with both enables toggling in unrelated patterns on the two clocks tests ordering while both pointers move and cross at once.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    typedef struct packed {
        logic full;
        logic almost;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic almost;
    } rd_flags_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= cells[raddr];
    end
endmodule

// File: rtl/xclk_fifo_wr_ctl.sv
module xclk_fifo_wr_ctl
    import xclk_fifo_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int AFULL_LVL = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic              push,
    output wr_flags_t         flags
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] rbin_sync;
    logic [PW-1:0] level;
    logic [PW-1:0] full_pattern;

    assign full_pattern = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
    assign rbin_sync    = PW'(gray_to_bin(32'(rgray_sync)));
    assign level        = wbin - rbin_sync;

    always_comb begin
        flags.full   = (wgray == full_pattern);
        flags.almost = (32'(level) >= AFULL_LVL);
    end

    assign push     = wr_en & ~flags.full;
    assign wbin_nxt = wbin + PW'(push);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= PW'(bin_to_gray(32'(wbin_nxt)));
        end
    end
endmodule

// File: rtl/xclk_fifo_rd_ctl.sv
module xclk_fifo_rd_ctl
    import xclk_fifo_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int AEMPTY_LVL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_clr,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic              pop,
    output rd_flags_t         flags
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] wbin_sync;
    logic [PW-1:0] level;

    assign wbin_sync = PW'(gray_to_bin(32'(wgray_sync)));
    assign level     = wbin_sync - rbin;

    always_comb begin
        flags.empty  = (rgray == wgray_sync);
        flags.almost = (32'(level) <= AEMPTY_LVL);
    end

    assign pop      = rd_en & ~flags.empty;
    assign rbin_nxt = rbin + PW'(pop);

    always_ff @(posedge clk) begin
        if (rst || ptr_clr) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= PW'(bin_to_gray(32'(rbin_nxt)));
        end
    end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int AFULL_LVL  = 12,
    parameter int AEMPTY_LVL = 2
) (
    input  logic              rst,
    input  logic              rd_ptr_clr,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_almost_full,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PW-1:0] wgray_in_rd, rgray_in_wr;
    logic          push, pop;
    wr_flags_t     wflags;
    rd_flags_t     rflags;

    xclk_fifo_wr_ctl #(.ADDR_W(ADDR_W), .AFULL_LVL(AFULL_LVL)) wr_ctl_i (
        .clk(wr_clk), .rst(rst), .wr_en(wr_en), .rgray_sync(rgray_in_wr),
        .wbin(wr_bin), .wgray(wr_gray), .push(push), .flags(wflags)
    );

    xclk_fifo_rd_ctl #(.ADDR_W(ADDR_W), .AEMPTY_LVL(AEMPTY_LVL)) rd_ctl_i (
        .clk(rd_clk), .rst(rst), .ptr_clr(rd_ptr_clr), .rd_en(rd_en),
        .wgray_sync(wgray_in_rd), .rbin(rd_bin), .rgray(rd_gray),
        .pop(pop), .flags(rflags)
    );

    xclk_fifo_sync #(.W(PW)) w2r_i (.clk(rd_clk), .rst(rst), .d(wr_gray), .q(wgray_in_rd));
    xclk_fifo_sync #(.W(PW)) r2w_i (.clk(wr_clk), .rst(rst), .d(rd_gray), .q(rgray_in_wr));

    xclk_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .wr_clk(wr_clk), .we(push), .waddr(wr_bin[ADDR_W-1:0]), .wdata(wr_data),
        .rd_clk(rd_clk), .rst(rst), .re(pop), .raddr(rd_bin[ADDR_W-1:0]), .rdata(rd_data)
    );

    assign wr_full         = wflags.full;
    assign wr_almost_full  = wflags.almost;
    assign rd_empty        = rflags.empty;
    assign rd_almost_empty = rflags.almost;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
    parameter int PW = 5
) (
    input logic          rst,
    input logic          rd_ptr_clr,
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wr_full,
    input logic          wr_almost_full,
    input logic          rd_empty,
    input logic          rd_almost_empty,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] rd_bin
);
    // R1: write side after reset
    assert_reset_wr_R1: assert property (@(posedge wr_clk)
        rst |=> (wr_bin == '0) && !wr_full && !wr_almost_full);

    // R1: read side after reset
    assert_reset_rd_R1: assert property (@(posedge rd_clk)
        rst |=> (rd_bin == '0) && rd_empty && rd_almost_empty);

    // R5: a write while full leaves the pointer in place
    assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_en && wr_full) |=> $stable(wr_bin));

    // R5: the write pointer advances by at most one per edge
    assert_wr_step_R5: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_bin == $past(wr_bin)) || (wr_bin == $past(wr_bin) + PW'(1)));

    // R6: a read while empty leaves the pointer in place
    assert_no_underflow_R6: assert property (@(posedge rd_clk) disable iff (rst)
        (rd_en && rd_empty && !rd_ptr_clr) |=> $stable(rd_bin));

    // R8: full implies the level is also above the almost-full threshold
    assert_full_afull_R8: assert property (@(posedge wr_clk) disable iff (rst)
        wr_full |-> wr_almost_full);

    // R9: empty implies the level is also below the almost-empty threshold
    assert_empty_aempty_R9: assert property (@(posedge rd_clk) disable iff (rst)
        rd_empty |-> rd_almost_empty);

    // R10: the read-pointer clear returns the read pointer to zero
    assert_ptr_clr_R10: assert property (@(posedge rd_clk) disable iff (rst)
        rd_ptr_clr |=> (rd_bin == '0));
endmodule

bind xclk_fifo xclk_fifo_chk #(.PW(ADDR_W + 1)) chk_i (
    .rst(rst), .rd_ptr_clr(rd_ptr_clr), .wr_clk(wr_clk), .rd_clk(rd_clk),
    .wr_en(wr_en), .rd_en(rd_en), .wr_full(wr_full), .wr_almost_full(wr_almost_full),
    .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty),
    .wr_bin(wr_bin), .rd_bin(rd_bin)
);

// File: tb/xclk_fifo_tb_top.sv
`timescale 1ns/1ps
module xclk_fifo_tb_top;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int AFULL  = 12;
    localparam int AEMPTY = 2;

    logic rst = 1'b1, rd_ptr_clr = 1'b0;
    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic wr_full, wr_almost_full, rd_empty, rd_almost_empty;

    int checks = 0, errors = 0, rx_cnt = 0;
    logic [DATA_W-1:0] expq [$];
    bit pend = 0;

    always #2 wr_clk = ~wr_clk;   // 250 MHz
    always #3 rd_clk = ~rd_clk;

    xclk_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AFULL_LVL(AFULL), .AEMPTY_LVL(AEMPTY)) dut_i (
        .rst(rst), .rd_ptr_clr(rd_ptr_clr), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_almost_full(wr_almost_full), .rd_clk(rd_clk), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard for every accepted read (R7)
    always @(posedge rd_clk) begin
        if (pend) begin
            if (expq.size() == 0) chk(0, "R7", "unexpected read data", int'(rd_data), -1);
            else begin
                logic [DATA_W-1:0] e;
                e = expq.pop_front();
                chk(rd_data == e, "R7", "read data order", int'(rd_data), int'(e));
                rx_cnt++;
            end
        end
        pend = rd_en && !rd_empty && !rst && !rd_ptr_clr;
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge rd_clk);
        rst = 1'b0;
        expq.delete();
        rx_cnt = 0;
        @(negedge wr_clk);
    endtask

    task automatic push_word(input logic [DATA_W-1:0] d, output bit took);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = d;
        took = !wr_full;
        if (took) expq.push_back(d);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_word();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #700000;
        chk(0, "R1", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit took;
        do_reset();
        // R1
        chk(rd_empty == 1, "R1", "empty after reset", rd_empty, 1);
        chk(rd_almost_empty == 1, "R1", "almost empty after reset", rd_almost_empty, 1);
        chk(wr_full == 0, "R1", "full after reset", wr_full, 0);
        chk(wr_almost_full == 0, "R1", "almost full after reset", wr_almost_full, 0);

        // R6: reads while empty are ignored
        @(negedge rd_clk); rd_en = 1'b1;
        repeat (4) @(negedge rd_clk);
        rd_en = 1'b0;
        chk(rd_empty == 1, "R6", "empty after reads on empty", rd_empty, 1);

        // R3: empty clears only after the write pointer crosses
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = 8'h5A; expq.push_back(8'h5A);
        @(posedge wr_clk); #1; wr_en = 1'b0;
        @(negedge rd_clk);
        chk(rd_empty == 1, "R3", "empty held after first write", rd_empty, 1);
        repeat (3) @(negedge rd_clk);
        chk(rd_empty == 0, "R3", "empty cleared after sync", rd_empty, 0);
        pop_word();
        chk(rd_empty == 1, "R2", "empty right after last read", rd_empty, 1);
        repeat (2) @(negedge rd_clk);
        chk(rx_cnt == 1, "R6", "word after ignored reads", rx_cnt, 1);

        // R11 / R8 / R2 / R5: fill past capacity
        repeat (6) @(negedge wr_clk);
        for (int k = 1; k <= DEPTH + 1; k++) begin
            int lvl;
            push_word(DATA_W'(8'h10 + k), took);
            lvl = (k > DEPTH) ? DEPTH : k;
            chk(took == (k <= DEPTH), "R5", "write accepted only when not full", took, k <= DEPTH);
            chk(wr_full == (k >= DEPTH), "R11", "full at capacity", wr_full, k >= DEPTH);
            chk(wr_almost_full == (lvl >= AFULL), "R8", "almost full threshold", wr_almost_full, lvl >= AFULL);
        end

        // R4: full clears only after the read pointer crosses
        repeat (4) @(negedge rd_clk);
        @(negedge rd_clk); rd_en = 1'b1;
        @(posedge rd_clk); #1; rd_en = 1'b0;
        @(negedge wr_clk);
        chk(wr_full == 1, "R4", "full held after first read", wr_full, 1);
        repeat (4) @(negedge wr_clk);
        chk(wr_full == 0, "R4", "full cleared after sync", wr_full, 0);
        chk(wr_almost_full == 1, "R8", "almost full at level 15", wr_almost_full, 1);

        // R9: drain and walk the almost-empty threshold
        for (int rem = DEPTH - 2; rem >= 0; rem--) begin
            pop_word();
            chk(rd_empty == (rem == 0), "R2", "empty while draining", rd_empty, rem == 0);
            chk(rd_almost_empty == (rem <= AEMPTY), "R9", "almost empty threshold", rd_almost_empty, rem <= AEMPTY);
        end
        repeat (2) @(negedge rd_clk);
        chk(expq.size() == 0, "R5", "dropped write left no entry", expq.size(), 0);

        // R10: read-pointer clear replays from address 0
        do_reset();
        for (int k = 0; k < 5; k++) push_word(DATA_W'(8'hA0 + k), took);
        repeat (4) @(negedge rd_clk);
        for (int k = 0; k < 3; k++) pop_word();
        repeat (2) @(negedge rd_clk);
        @(negedge rd_clk); rd_ptr_clr = 1'b1;
        @(negedge rd_clk); rd_ptr_clr = 1'b0;
        expq.delete();
        for (int k = 0; k < 5; k++) expq.push_back(DATA_W'(8'hA0 + k));
        chk(rd_empty == 0, "R10", "not empty after clear", rd_empty, 0);
        chk(rd_almost_empty == 0, "R10", "level 5 after clear", rd_almost_empty, 0);
        repeat (4) @(negedge wr_clk);
        chk(wr_almost_full == 0, "R10", "write level after clear", wr_almost_full, 0);
        for (int k = 0; k < 5; k++) pop_word();
        chk(rd_empty == 1, "R10", "empty after replay", rd_empty, 1);
        push_word(8'hB5, took);
        repeat (4) @(negedge rd_clk);
        pop_word();
        repeat (2) @(negedge rd_clk);
        chk(expq.size() == 0, "R10", "write pointer kept", expq.size(), 0);

        // R7: concurrent traffic
        do_reset();
        fork
            begin
                int sent;
                sent = 0;
                for (int i = 0; sent < 40; i++) begin
                    if (i % 3 == 2) @(negedge wr_clk);
                    else begin
                        push_word(DATA_W'(8'h40 + sent), took);
                        if (took) sent++;
                    end
                end
            end
            begin
                for (int i = 0; i < 3000 && rx_cnt < 40; i++) begin
                    @(negedge rd_clk);
                    rd_en = (i % 4 != 3);
                end
                @(negedge rd_clk);
                rd_en = 1'b0;
            end
        join
        repeat (3) @(negedge rd_clk);
        chk(rx_cnt == 40, "R7", "stream word count", rx_cnt, 40);
        chk(expq.size() == 0, "R7", "stream scoreboard drained", expq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule